// File: doc/BRIEF.md
# Two-Channel DMA Bus-Mode Arbiter

This block decides which of two DMA channels owns each transfer slot on a shared bus, and when the bus goes back to the CPU or to another master. Each channel runs either as a burst transfer, which keeps the bus until it finishes, or as a cycle-steal transfer, which hands the bus back after every transfer unit. Priority is fixed, and the lower channel index wins. Address generation, data movement and request decoding are handled elsewhere. The arbiter only counts units, issues a one-hot grant, and drives a bus-hold signal.

A channel is started with a unit count. The unit currently on the bus is retired by a one-cycle `unit_done` pulse from the transfer engine. A grant moves only at a unit boundary, or when no channel holds the bus. After a cycle-steal unit the bus would normally drop for one cycle. When a burst channel is still pending, that slot goes to the burst channel instead. A cycle-steal channel and a burst channel therefore interleave unit by unit, and the bus stays held until every competing burst has finished.

Top module: `dma_busmode_arb`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `grant`, `bus_hold`, `busy` and `done_flag` are all zero.
- R2: `start[i]` loads channel i's count from `load_count[i*CNT_W +: CNT_W]` only when the channel is idle and the count is non-zero. A start while the channel is busy, or with count zero, is ignored. `busy[i]` rises at the loading edge.
- R3: Priority is fixed, and channel 0 beats channel 1. When both are burst mode (`burst_mode[i]`=1, 0 means cycle-steal), channel 0 moves all of its units before channel 1 moves any.
- R4: `grant` is bit i for channel i and has at most one bit set. A held grant changes only at an edge where `unit_done` is high.
- R5: If channel 1 holds the bus and channel 0 becomes pending, channel 0 is granted at the edge that retires channel 1's current unit.
- R6: After a cycle-steal unit, that channel is not granted in the next cycle. With no other burst pending, the grant drops to zero for exactly one cycle and then returns while units remain.
- R7: After a cycle-steal unit, if a burst channel is pending, that channel is granted at once and `bus_hold` stays high. A cycle-steal channel 0 and a burst channel 1 alternate units 0,1,0,1 until channel 0 is exhausted.
- R8: `bus_hold` is high exactly while a grant is held. It falls in the cycle after the last pending unit is retired when no other request is pending.
- R9: When a channel's last unit is retired, `busy[i]` falls and `done_flag[i]` rises. `done_flag[i]` clears at the next accepted start of that channel.
- R10: A `unit_done` pulse while no grant is held changes no count, grant or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | NCH | Per-channel start pulse |
| load_count | input | NCH*CNT_W | Per-channel unit count, channel i at bits i*CNT_W |
| burst_mode | input | NCH | 1 = burst, 0 = cycle-steal, per channel |
| unit_done | input | 1 | Granted channel finished one transfer unit |
| grant | output | NCH | One-hot slot owner |
| bus_hold | output | 1 | DMA keeps the bus |
| busy | output | NCH | Channel has units left |
| done_flag | output | NCH | Channel finished its last start |

## Verification
The hardest case to reach is a cycle-steal request that arrives in the middle of a lower-priority burst. It must land on the same edge that retires a burst unit, so that preemption and the following interleave can both be observed. The bench reaches it by starting channel 1 in burst mode, then raising channel 0's start together with the first `unit_done` pulse. A single-cycle handshake model then retires every granted unit, and the bench compares the cycle-by-cycle grant sequence and the bus-hold level against hand-derived patterns.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {
    MODE_STEAL = 1'b0,
    MODE_BURST = 1'b1
  } xfer_mode_e;

  localparam int unsigned DEF_NCH   = 2;
  localparam int unsigned DEF_CNT_W = 8;
endpackage

// File: rtl/dma_chan_count.sv
module dma_chan_count #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  input  logic             unit_dec,
  output logic             busy,
  output logic             busy_next,
  output logic             done_flag
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             accept;
  logic             last_unit;

  assign accept    = start && (cnt_q == '0) && (load_val != '0);
  assign last_unit = unit_dec && (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (accept) begin
      cnt_d = load_val;
    end else if (unit_dec && (cnt_q != '0)) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  assign busy_next = (cnt_d != '0);
  assign busy      = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      done_flag <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (accept) begin
        done_flag <= 1'b0;
      end else if (last_unit) begin
        done_flag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_slot_pick.sv
module dma_slot_pick #(
  parameter int unsigned NCH = 2
) (
  input  logic [NCH-1:0] pending_next,
  input  logic [NCH-1:0] burst_mask,
  input  logic [NCH-1:0] owner,
  input  logic           unit_done,
  output logic [NCH-1:0] grant_d
);
  logic           slot_open;
  logic           steal_retired;
  logic [NCH-1:0] cand;
  logic [NCH-1:0] pick;
  logic           found;

  assign slot_open     = (owner == '0) || unit_done;
  assign steal_retired = unit_done && ((owner & ~burst_mask) != '0);

  // after a cycle-steal unit only burst channels may take the slot
  assign cand = steal_retired ? (pending_next & burst_mask & ~owner) : pending_next;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (!found && cand[i]) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  assign grant_d = slot_open ? pick : owner;
endmodule

// File: rtl/dma_busmode_arb.sv
module dma_busmode_arb #(
  parameter int unsigned NCH   = dma_arb_pkg::DEF_NCH,
  parameter int unsigned CNT_W = dma_arb_pkg::DEF_CNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NCH-1:0]     start,
  input  logic [NCH*CNT_W-1:0] load_count,
  input  logic [NCH-1:0]     burst_mode,
  input  logic               unit_done,
  output logic [NCH-1:0]     grant,
  output logic               bus_hold,
  output logic [NCH-1:0]     busy,
  output logic [NCH-1:0]     done_flag
);
  logic [NCH-1:0] grant_q;
  logic [NCH-1:0] grant_d;
  logic [NCH-1:0] pend_next;
  logic           hold_q;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dma_chan_count #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .start     (start[g]),
      .load_val  (load_count[g*CNT_W +: CNT_W]),
      .unit_dec  (unit_done && grant_q[g]),
      .busy      (busy[g]),
      .busy_next (pend_next[g]),
      .done_flag (done_flag[g])
    );
  end

  dma_slot_pick #(.NCH(NCH)) u_pick (
    .pending_next (pend_next),
    .burst_mask   (burst_mode),
    .owner        (grant_q),
    .unit_done    (unit_done),
    .grant_d      (grant_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      hold_q  <= 1'b0;
    end else begin
      grant_q <= grant_d;
      hold_q  <= (grant_d != '0);
    end
  end

  assign grant    = grant_q;
  assign bus_hold = hold_q;
endmodule

// File: rtl/dma_busmode_arb_chk.sv
module dma_busmode_arb_chk #(
  parameter int unsigned NCH = 2
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] start,
  input logic [NCH-1:0] burst_mode,
  input logic           unit_done,
  input logic [NCH-1:0] grant,
  input logic           bus_hold,
  input logic [NCH-1:0] busy,
  input logic [NCH-1:0] done_flag
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (grant == '0) && !bus_hold && (busy == '0) && (done_flag == '0));

  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_grant_stable_R4: assert property (@(posedge clk) disable iff (rst)
    ((grant != '0) && !unit_done) |=> $stable(grant));

  assert_hold_tracks_grant_R8: assert property (@(posedge clk) disable iff (rst)
    bus_hold == (grant != '0));

  assert_idle_done_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    ((grant == '0) && unit_done && (start == '0)) |=> $stable(busy) && $stable(done_flag));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assert_steal_gap_R6: assert property (@(posedge clk) disable iff (rst)
      (grant[i] && unit_done && !burst_mode[i]) |=> !grant[i]);

    assert_steal_interleave_R7: assert property (@(posedge clk) disable iff (rst)
      (grant[i] && unit_done && !burst_mode[i] && ((busy & burst_mode & ~grant) != '0))
      |=> (bus_hold && !grant[i]));

    assert_done_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
      $fell(busy[i]) |-> done_flag[i]);
  end
endmodule

bind dma_busmode_arb dma_busmode_arb_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .burst_mode (burst_mode),
  .unit_done  (unit_done),
  .grant      (grant),
  .bus_hold   (bus_hold),
  .busy       (busy),
  .done_flag  (done_flag)
);

// File: tb/tb_dma_busmode_arb.sv
module tb_dma_busmode_arb;
  localparam int NCH   = 2;
  localparam int CNT_W = 8;

  logic                 clk = 1'b0;
  logic                 rst;
  logic [NCH-1:0]       start;
  logic [NCH*CNT_W-1:0] load_count;
  logic [NCH-1:0]       burst_mode;
  logic                 unit_done;
  logic [NCH-1:0]       grant;
  logic                 bus_hold;
  logic [NCH-1:0]       busy;
  logic [NCH-1:0]       done_flag;

  int checks = 0;
  int fails  = 0;

  dma_busmode_arb #(.NCH(NCH), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .start(start), .load_count(load_count),
    .burst_mode(burst_mode), .unit_done(unit_done), .grant(grant),
    .bus_hold(bus_hold), .busy(busy), .done_flag(done_flag)
  );

  always #5 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // serve granted units one per cycle; slot k grant stored at bits 2k+1:2k
  task automatic run_slots(output int n, output logic [31:0] gseq, output int holdbad);
    n = 0; gseq = '0; holdbad = 0;
    for (int k = 0; k < 16; k++) begin
      if (grant == '0 && busy == '0) break;
      gseq[2*k +: 2] = grant;
      if (bus_hold != (grant != '0)) holdbad++;
      n++;
      unit_done = (grant != '0);
      step();
    end
    unit_done = 1'b0;
  endtask

  task automatic launch(logic [1:0] st, int c0, int c1, logic [1:0] md);
    start = st;
    load_count = {CNT_W'(c1), CNT_W'(c0)};
    burst_mode = md;
  endtask

  task automatic expect_seq(string tag, int exp_n, logic [31:0] exp_seq);
    int n; logic [31:0] s; int hb;
    run_slots(n, s, hb);
    chk({tag, " slot count"}, n, exp_n);
    chk({tag, " grant sequence"}, int'(s), int'(exp_seq));
    chk({tag, " R8 hold tracks grant"}, hb, 0);
    chk({tag, " R8 hold released at end"}, int'(bus_hold), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1; start = '0; load_count = '0; burst_mode = '0; unit_done = 1'b0;
    step(); step();
    chk("R1 grant", int'(grant), 0);
    chk("R1 hold", int'(bus_hold), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done_flag), 0);
    rst = 1'b0;
    step();
  endtask

  task automatic t_idle_ignores();
    unit_done = 1'b1;
    step(); step(); step();
    unit_done = 1'b0;
    chk("R10 grant after idle done", int'(grant), 0);
    chk("R10 busy after idle done", int'(busy), 0);
    chk("R10 flag after idle done", int'(done_flag), 0);
    launch(2'b01, 0, 0, 2'b01);
    step();
    start = '0;
    chk("R2 zero count ignored busy", int'(busy), 0);
    chk("R2 zero count ignored grant", int'(grant), 0);
  endtask

  task automatic t_steal_alone();
    launch(2'b01, 3, 0, 2'b00);
    step();
    start = '0;
    chk("R2 busy on load", int'(busy), 1);
    chk("R6 first grant", int'(grant), 1);
    // 01,00,01,00,01
    expect_seq("R6 steal gap", 5, 32'h111);
    chk("R9 done flag ch0", int'(done_flag), 1);
    chk("R9 busy cleared", int'(busy), 0);
  endtask

  task automatic t_both_burst();
    launch(2'b11, 2, 3, 2'b11);
    step();
    start = '0;
    chk("R9 done cleared on start", int'(done_flag), 0);
    // 01,01,10,10,10
    expect_seq("R3 burst priority", 5, 32'h2A5);
  endtask

  task automatic t_steal_into_burst();
    launch(2'b10, 0, 4, 2'b10);
    step();
    chk("R5 ch1 burst granted", int'(grant), 2);
    unit_done = 1'b1;
    launch(2'b01, 2, 4, 2'b10);
    step();
    start = '0; unit_done = 1'b0;
    chk("R5 ch0 takes next slot", int'(grant), 1);
    // 01,10,01,10,10
    expect_seq("R7 interleave", 5, 32'h299);
  endtask

  task automatic t_burst_preempt();
    launch(2'b10, 0, 3, 2'b10);
    step();
    unit_done = 1'b1;
    launch(2'b01, 2, 3, 2'b11);
    step();
    start = '0; unit_done = 1'b0;
    chk("R5 burst ch0 preempts", int'(grant), 1);
    // 01,01,10,10
    expect_seq("R3 ch1 resumes after ch0", 4, 32'hA5);
  endtask

  task automatic t_stable_grant();
    launch(2'b01, 2, 0, 2'b01);
    step();
    launch(2'b11, 7, 1, 2'b11);
    for (int k = 0; k < 3; k++) begin
      step();
      start = '0;
      chk("R4 grant held without unit_done", int'(grant), 1);
    end
    // ch0 keeps count 2 (restart ignored), then ch1 once: 01,01,10
    expect_seq("R2 restart while busy ignored", 3, 32'h25);
  endtask

  task automatic t_both_steal();
    launch(2'b11, 2, 1, 2'b00);
    step();
    start = '0;
    // 01,00,01,00,10
    expect_seq("R6 two steal channels", 5, 32'h211);
    chk("R9 both done", int'(done_flag), 3);
    launch(2'b10, 0, 1, 2'b10);
    step();
    start = '0;
    chk("R9 ch1 flag cleared, ch0 kept", int'(done_flag), 1);
    expect_seq("R9 single unit", 1, 32'h2);
    chk("R9 ch1 flag set again", int'(done_flag), 3);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_idle_ignores();
    t_steal_alone();
    t_both_burst();
    t_steal_into_burst();
    t_burst_preempt();
    t_stable_grant();
    t_both_steal();
    summary();
    $finish;
  end
endmodule